// File: doc/BRIEF.md
# Video controller host port decoder

This block is the processor-facing port of a tile-based video controller. It exposes two word-wide ports on a small bus. One is a data port. The other serves as a control port on writes and as a status port on reads. Writes to the control port either load one of the controller's byte-wide setup registers or build a two-word access command. That command fixes a target memory, a direction and a 16-bit address.

Data-port traffic then reads or writes the video memory, the palette (colour) memory or the vertical-scroll memory at the command address. After every data-port access, read or write, whether or not it reached a memory, the address advances by the step value held in setup register 15. A 32-bit host access is issued as two consecutive word accesses, upper half first.

The register image and the DMA mode bits of the command are exported to the rest of the controller. DMA execution and rendering live elsewhere. The video memory size is a parameter: the full-size instance sets 65536 bytes, and the default keeps the array small.

Top module: `vdp_host_port`

## Requirements
- R1: Synchronous active-high reset clears the setup registers, the address, the access code, the pending-second-word flag and the captured status flags. After reset the register image and `dma_mode` are zero and a status read returns 16'h0200.
- R2: When no second word is pending, a control word whose bits [15:13] are 3'b100 writes bits [7:0] into setup register number bits [12:8]. Register numbers 24 to 31 are ignored. The address and the access code are left unchanged.
- R3: When no second word is pending, any other control word is a first command word. Its bits [15:14] become code bits [1:0], its bits [13:0] become address bits [13:0], address bits [15:14] become zero, and the pending flag is set.
- R4: While the pending flag is set, the next control word is always taken as the second word, even when it carries the register prefix. Its bits [1:0] become address bits [15:14], its bits [7:4] become code bits [5:2], and the flag is cleared. Code bits [5:4] appear on `dma_mode`.
- R5: Code bits [3:0] select the access: 0 video read, 1 video write, 3 palette write, 8 palette read, 4 scroll read, 5 scroll write.
- R6: Each data-port read or write advances the address by setup register 15, modulo 2^16. Memory accesses use the address with bit 0 forced to zero.
- R7: The memory sizes are VRAM_BYTES (65536 at full size), 128 bytes for the palette memory and 80 bytes for the scroll memory. An access at or beyond the size is dropped: a write stores nothing and a read returns zero.
- R8: A data write under a read code, a data read under a write code, and any access under an unlisted code touch no memory. Such reads return zero.
- R9: A status read returns bit 9 equal to the inverse of `fifo_has_data` and bits [8:0] equal to `status_flags`, each sampled one clock earlier. Bits [15:10] are zero. A status read has no side effect.
- R10: Bus word offsets 0 and 1 both reach the data port, and offsets 2 and 3 both reach the control and status port. Two consecutive word writes act as a 32-bit access with the upper half first.
- R11: Reset leaves all three memories reading zero at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ofs | input | 2 | Word offset: bit 1 set selects the control/status port |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access; wins over bus_rd |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_rd |
| fifo_has_data | input | 1 | Write FIFO holds data (reported inverted in status bit 9) |
| status_flags | input | 9 | FIFO full, vertical interrupt, sprite overflow, sprite collision, odd frame, vertical blank, horizontal blank, DMA busy, PAL, from bit 8 down |
| reg_image | output | NREG*8 | Setup registers, register n at bits [8n+7:8n] |
| dma_mode | output | 2 | Code bits [5:4] of the latched command |

## Verification
The hardest case to reach is a control word carrying the register prefix that arrives while the second command word is pending. It is forced by a first word followed by such a word, chosen so that the two interpretations route the next data write to different memories; reading back both memories shows which interpretation was taken. The address wrap from the top of the 16-bit space is driven by a command that targets the last even address with a step of four. The dropped write at 16'hFFFE and the landed write at 16'h0002 then separate the wrap from a carry into a wider counter. Out-of-range and wrong-direction accesses are each followed by an in-range readback at the next address, which shows that the address still advanced.

// File: rtl/vdp_hp_pkg.sv
package vdp_hp_pkg;

  localparam int ADDR_W = 16;
  localparam int CODE_W = 6;
  localparam int NTGT   = 3;   // 0 video, 1 palette, 2 scroll

  localparam logic [2:0] REG_PREFIX = 3'b100;

  typedef struct packed {
    logic [NTGT-1:0] rd;
    logic [NTGT-1:0] wr;
  } acc_t;

  // Map code bits [3:0] onto one-hot read/write target selects.
  function automatic acc_t decode_code(input logic [3:0] c);
    acc_t a;
    a = '0;
    case (c)
      4'h0: a.rd[0] = 1'b1;
      4'h1: a.wr[0] = 1'b1;
      4'h3: a.wr[1] = 1'b1;
      4'h8: a.rd[1] = 1'b1;
      4'h4: a.rd[2] = 1'b1;
      4'h5: a.wr[2] = 1'b1;
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/vdp_word_mem.sv
module vdp_word_mem #(
  parameter int WORDS = 64,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);

  logic [15:0]      mem [WORDS];
  logic [WORDS-1:0] vld;

  // Storage array carries no reset, so it maps onto plain RAM.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  // One valid bit per word gives single-cycle clearing on reset.
  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (we) vld[idx] <= 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) < WORDS) begin
      if (vld[idx]) rdata = mem[idx];
    end
  end

  // R11
  mem_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == 16'h0000);

  // R5
  mem_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (idx != $past(idx)) || (rdata == $past(wdata)));

endmodule

// File: rtl/vdp_cmd_unit.sv
module vdp_cmd_unit
  import vdp_hp_pkg::*;
#(
  parameter int NREG     = 24,
  parameter int STEP_REG = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_word,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code,
  output logic [NREG*8-1:0] regs_flat
);

  logic [7:0]        regs_q [NREG];
  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] code_q;
  logic              pend_q;
  logic              has_prefix;
  logic              reg_wr;

  assign has_prefix = (ctl_word[15:13] == REG_PREFIX);
  assign reg_wr     = ctl_we && !pend_q && has_prefix;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
    end else if (ctl_we) begin
      if (pend_q) begin
        addr_q[15:14] <= ctl_word[1:0];
        code_q[5:2]   <= ctl_word[7:4];
        pend_q        <= 1'b0;
      end else if (!has_prefix) begin
        addr_q <= {2'b00, ctl_word[13:0]};
        code_q <= {4'b0000, ctl_word[15:14]};
        pend_q <= 1'b1;
      end
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(regs_q[STEP_REG]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs_q[i] <= '0;
      else if (reg_wr && (ctl_word[12:8] == 5'(i)))
        regs_q[i] <= ctl_word[7:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs_q[g];
  end

  assign addr = addr_q;
  assign code = code_q;

  // R3
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !pend_q && !has_prefix) |=>
      pend_q && (addr_q[15:14] == 2'b00) && (code_q[1:0] == $past(ctl_word[15:14])));

  // R4
  second_word_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && pend_q) |=> !pend_q && (addr_q[13:0] == $past(addr_q[13:0])));

  // R2
  regwr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> $stable(addr_q) && $stable(code_q) && !pend_q);

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ctl_we) |=> addr_q == $past(addr_q) + ADDR_W'($past(regs_q[STEP_REG])));

endmodule

// File: rtl/vdp_stat_unit.sv
module vdp_stat_unit #(
  parameter int NFLAG = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_has_data,
  input  logic [NFLAG-1:0] flags_in,
  output logic [15:0]      word
);

  localparam int PAD = 16 - NFLAG - 1;

  logic             fifo_q;
  logic [NFLAG-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      fifo_q  <= fifo_has_data;
      flags_q <= flags_in;
    end
  end

  assign word = {{PAD{1'b0}}, ~fifo_q, flags_q};

  // R1
  stat_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> word == 16'h0200);

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
  import vdp_hp_pkg::*;
#(
  parameter int VRAM_BYTES  = 4096,
  parameter int CRAM_BYTES  = 128,
  parameter int VSRAM_BYTES = 80,
  parameter int NREG        = 24,
  parameter int STEP_REG    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_ofs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              fifo_has_data,
  input  logic [8:0]        status_flags,
  output logic [NREG*8-1:0] reg_image,
  output logic [1:0]        dma_mode
);

  localparam int TGT_BYTES [NTGT] = '{VRAM_BYTES, CRAM_BYTES, VSRAM_BYTES};

  logic              is_ctl;
  logic              ctl_we, data_wr, data_rd, step;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;
  logic [ADDR_W:0]   addr_even;
  acc_t              acc;
  logic [15:0]       stat_word;
  logic [NTGT-1:0]   in_rng, t_we, t_hit;
  logic [15:0]       t_rdata [NTGT];
  logic [15:0]       mem_rdata;

  assign is_ctl  = bus_ofs[1];
  assign ctl_we  = bus_wr && is_ctl;
  assign data_wr = bus_wr && !is_ctl;
  assign data_rd = bus_rd && !bus_wr && !is_ctl;
  assign step    = data_wr || data_rd;

  vdp_cmd_unit #(.NREG(NREG), .STEP_REG(STEP_REG)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_word  (bus_wdata),
    .step      (step),
    .addr      (addr),
    .code      (code),
    .regs_flat (reg_image)
  );

  vdp_stat_unit #(.NFLAG(9)) u_stat (
    .clk           (clk),
    .rst           (rst),
    .fifo_has_data (fifo_has_data),
    .flags_in      (status_flags),
    .word          (stat_word)
  );

  assign acc       = decode_code(code[3:0]);
  assign addr_even = {1'b0, addr[ADDR_W-1:1], 1'b0};
  assign dma_mode  = code[5:4];

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    localparam int WORDS = TGT_BYTES[t] / 2;
    localparam int TAW   = (WORDS > 1) ? $clog2(WORDS) : 1;

    assign in_rng[t] = addr_even < (ADDR_W+1)'(TGT_BYTES[t]);
    assign t_we[t]   = data_wr && acc.wr[t] && in_rng[t];
    assign t_hit[t]  = data_rd && acc.rd[t] && in_rng[t];

    vdp_word_mem #(.WORDS(WORDS)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .we    (t_we[t]),
      .idx   (addr[TAW:1]),
      .wdata (bus_wdata),
      .rdata (t_rdata[t])
    );
  end

  always_comb begin
    mem_rdata = '0;
    for (int t = 0; t < NTGT; t++) begin
      if (t_hit[t]) mem_rdata = mem_rdata | t_rdata[t];
    end
  end

  always_comb begin
    if (bus_rd && is_ctl) bus_rdata = stat_word;
    else if (data_rd)     bus_rdata = mem_rdata;
    else                  bus_rdata = '0;
  end

  // R8
  wrong_dir_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && (acc.rd == '0)) |-> bus_rdata == 16'h0000);

  // R8
  wrong_dir_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && (acc.wr == '0)) |-> t_we == '0);

  // R9
  stat_fifo_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_ctl && !$past(rst)) |-> bus_rdata[9] == !$past(fifo_has_data));

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({t_we, t_hit}));

endmodule

// File: tb/sim_vdp_host_port.sv
module sim_vdp_host_port;

  localparam int CLK_PER = 10;
  localparam int NREG    = 24;
  localparam int NV      = 57;

  // {req, op(0 wr / 1 rd), word offset, wdata, expected}
  localparam logic [43:0] TBL [NV] = '{
    44'h2_0_2_8F02_0000,  // R2 step register = 2
    44'h3_0_2_4010_0000,  // R3 video write @0x10
    44'h4_0_2_0000_0000,  // R4
    44'h5_0_0_1234_0000,  // R5
    44'hA_0_1_ABCD_0000,  // R10 offset 1 is data port
    44'h3_0_2_0010_0000,  // R3 video read @0x10
    44'h4_0_2_0000_0000,
    44'h5_1_0_0000_1234,
    44'hA_1_1_0000_ABCD,
    44'h6_1_0_0000_0000,  // R6 next word unwritten
    44'h3_0_2_C07E_0000,  // palette write @0x7E
    44'h4_0_2_0000_0000,
    44'h5_0_0_0EEE_0000,
    44'h7_0_0_0555_0000,  // R7 @0x80 dropped
    44'h3_0_2_007E_0000,  // palette read (code 8)
    44'h4_0_2_0020_0000,
    44'h5_1_0_0000_0EEE,
    44'h7_1_0_0000_0000,
    44'h3_0_2_404E_0000,  // scroll write @0x4E
    44'h4_0_2_0010_0000,
    44'h5_0_0_03FF_0000,
    44'h7_0_0_0111_0000,  // @0x50 dropped
    44'h3_0_2_004E_0000,  // scroll read
    44'h4_0_2_0010_0000,
    44'h5_1_0_0000_03FF,
    44'h7_1_0_0000_0000,
    44'h3_0_2_4020_0000,  // R4 prefix word while pending
    44'h4_0_2_8010_0000,
    44'h4_0_0_5555_0000,
    44'h3_0_2_0020_0000,
    44'h4_0_2_0010_0000,
    44'h4_1_0_0000_5555,
    44'h3_0_2_0020_0000,
    44'h4_0_2_0000_0000,
    44'h4_1_0_0000_0000,
    44'h3_0_2_0010_0000,  // R8 write under read code
    44'h4_0_2_0000_0000,
    44'h8_0_0_9999_0000,
    44'h8_1_0_0000_ABCD,
    44'h3_0_2_0010_0000,
    44'h4_0_2_0000_0000,
    44'h8_1_0_0000_1234,
    44'h3_0_2_4010_0000,  // R8 read under write code
    44'h4_0_2_0000_0000,
    44'h8_1_0_0000_0000,
    44'h6_0_0_7777_0000,  // R6 read also stepped
    44'h3_0_2_0012_0000,
    44'h4_0_2_0000_0000,
    44'h6_1_0_0000_7777,
    44'h3_0_2_4010_0000,  // R8 unlisted code 9
    44'h4_0_2_0020_0000,
    44'h8_0_0_DEAD_0000,
    44'h3_0_2_0010_0000,
    44'h4_0_2_0000_0000,
    44'h8_1_0_0000_1234,
    44'h9_1_2_0000_01A5,  // R9 both status offsets
    44'h9_1_3_0000_01A5
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        bus_ofs = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              fifo_has_data = 1'b0;
  logic [8:0]        status_flags = '0;
  logic [NREG*8-1:0] reg_image;
  logic [1:0]        dma_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  vdp_host_port u0 (
    .clk           (clk),
    .rst           (rst),
    .bus_ofs       (bus_ofs),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .fifo_has_data (fifo_has_data),
    .status_flags  (status_flags),
    .reg_image     (reg_image),
    .dma_mode      (dma_mode)
  );

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic rd, input logic [1:0] ofs, input logic [15:0] wd,
                        output logic [15:0] rdv);
    @(negedge clk);
    bus_rd    = rd;
    bus_wr    = !rd;
    bus_ofs   = ofs;
    bus_wdata = wd;
    #(CLK_PER/4);
    rdv = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic ctl(input logic [15:0] w);
    logic [15:0] d;
    bus_op(1'b0, 2'd2, w, d);
  endtask

  task automatic dwr(input logic [15:0] w);
    logic [15:0] d;
    bus_op(1'b0, 2'd0, w, d);
  endtask

  task automatic drd(input logic [1:0] ofs, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_op(1'b1, ofs, 16'h0000, d);
    chk(req, 192'(d), 192'(exp));
  endtask

  function automatic logic [7:0] reg_at(input int i);
    return reg_image[i*8 +: 8];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [191:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 regs", 192'(reg_image), 192'(0));
    chk("R1 dma", 192'(dma_mode), 192'(0));
    drd(2'd2, 16'h0200, "R1 status");
    ctl(16'h0010); ctl(16'h0000);
    drd(2'd0, 16'h0000, "R11 video after reset");

    @(negedge clk);
    fifo_has_data = 1'b1;
    status_flags  = 9'h1A5;

    for (int k = 0; k < NV; k++) begin
      logic [43:0] v;
      logic [15:0] d;
      v = TBL[k];
      bus_op(v[36], v[33:32], v[31:16], d);
      if (v[36]) chk($sformatf("R%0d step %0d", v[43:40], k), 192'(d), 192'(v[15:0]));
    end

    // R2 register contents, unmapped numbers ignored
    chk("R2 step reg", 192'(reg_at(15)), 192'(8'h02));
    snap = 192'(reg_image);
    ctl(16'h9855);
    chk("R2 reg 24 ignored", 192'(reg_image), snap);
    ctl(16'h8A33);
    chk("R2 reg 10", 192'(reg_at(10)), 192'(8'h33));

    // R4 DMA bits, R2 register write keeps code
    ctl(16'h4000); ctl(16'h0080);
    chk("R4 dma mode", 192'(dma_mode), 192'(2'd2));
    ctl(16'h8101);
    chk("R2 code kept", 192'(dma_mode), 192'(2'd2));
    chk("R2 reg 1", 192'(reg_at(1)), 192'(8'h01));

    // R6 odd step with bit 0 forced low
    ctl(16'h8F01);
    ctl(16'h4030); ctl(16'h0000);
    dwr(16'h1111); dwr(16'h2222); dwr(16'h3333);
    ctl(16'h0030); ctl(16'h0000);
    drd(2'd0, 16'h2222, "R6 odd step a");
    drd(2'd0, 16'h2222, "R6 odd step b");
    drd(2'd0, 16'h3333, "R6 odd step c");

    // R6 wrap at 16 bits, R7 drop at top address
    ctl(16'h8F04);
    ctl(16'h7FFE); ctl(16'h0013);
    dwr(16'hAAAA); dwr(16'h0BBB);
    ctl(16'h0002); ctl(16'h0010);
    drd(2'd0, 16'h0BBB, "R6 wrap");

    // R9 one-cycle capture of new flags
    @(negedge clk);
    fifo_has_data = 1'b0;
    status_flags  = 9'h000;
    @(posedge clk);
    drd(2'd3, 16'h0200, "R9 flags update");

    // R11 reset mid-run clears memories and state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 regs again", 192'(reg_image), 192'(0));
    chk("R1 dma again", 192'(dma_mode), 192'(0));
    ctl(16'h0010); ctl(16'h0000);
    drd(2'd0, 16'h0000, "R11 video cleared");
    ctl(16'h007E); ctl(16'h0020);
    drd(2'd0, 16'h0000, "R11 palette cleared");
    ctl(16'h0002); ctl(16'h0010);
    drd(2'd0, 16'h0000, "R11 scroll cleared");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule